// File: doc/BRIEF.md
# Timestamped Fault Event Logger

This block keeps a short history of fault events seen by a multi-rail power supervisor. Five fault classes can be reported: output overvoltage, output undervoltage, input overvoltage, input undervoltage and a qualification-window timeout on a rail that did not reach power-good in time. Each class comes with an 8-bit page number. An event is stored only if the global enable is set and the enable for its class passes. For input classes that enable is a bit in the master register. For output and timeout classes it is a bit in the enable register of the page the event names.

Each stored entry holds a one-hot fault code, the page number and the value of a free-running seconds counter. That counter advances once every programmable number of clock cycles. Software loads it to wall time and trims the tick count to the real clock rate. The log lives in an on-chip array. Software reads it through an eight-register port: it sets a read index in the control register and then reads the data word and the timestamp of that entry.

When several classes fire in the same cycle, all of them are stored in that cycle, in a fixed priority order. Once the array is full, new events are dropped.

Top module: `fault_evlog`

## Requirements
- R1: After reset the seconds counter, entry count, read index, page select, master enable and all page enables are zero, and the tick register (address 2) holds CLK_HZ.
- R2: The seconds register (address 1) is loaded by a write and restarts its sub-second phase. Afterwards it reads `load + floor(M/T)` after M clock edges, where T is the tick register value.
- R3: The tick register is read/write. A write restarts the sub-second phase. A value of 0 or 1 advances the seconds counter on every cycle.
- R4: The log data register (address 6) returns {16'b0, type, page}. Type bit 0 marks output OV, bit 1 output UV, bit 2 input OV, bit 3 input UV and bit 4 a timeout. Request bit k of `flt_req` is class k.
- R5: The log time register (address 7) returns the seconds value held at the clock edge on which the selected entry was captured.
- R6: Master enable register (address 4): bit 0 gates all logging, bit 2 gates input OV and bit 3 gates input UV. Bits 1 and 31:4 read as zero.
- R7: The page-enable register (address 5) reads and writes the enables of the page held in the select register (address 0). Its bit 0 gates output OV, bit 1 output UV and bit 2 timeout events for that page. Output and timeout events naming a page at or above NUM_PAGES are not logged.
- R8: Events accepted in the same cycle fill consecutive entries in class order 0 to 4.
- R9: When the log holds DEPTH entries, further events are dropped and the count stays at DEPTH.
- R10: Writing control (address 3) with bit 0 set empties the log at once and drops any events in that cycle. Bit 0 always reads back as 0.
- R11: A read index at or above the entry count makes the data and time registers read zero.
- R12: Control bits 31:24 report the entry count and ignore writes. Bits 23:16 hold the read index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| flt_req | input | 5 | One request bit per fault class, one cycle per event |
| flt_page | input | 40 | Page number of class k in bits 8k+7:8k |

## Verification
The assertions assume that each fault request is a one-cycle pulse sampled on one edge. They also assume that nothing but a control write with bit 0 set ever lowers the entry count, and that the seconds counter only moves by a load or by a step of one. The bench drives each event for exactly one edge. It changes registers only through whole write cycles, so enables and clears take effect on a known edge. It uses a small build (depth 4, four pages, five ticks) so that every combination of simultaneous requests and every master setting can be swept, and it computes the expected order, saturation and timestamps by arithmetic.

// File: rtl/flog_pkg.sv
package flog_pkg;
   localparam int NCLS = 5;
   localparam int PGW  = 8;
   localparam int AW   = 3;

   typedef enum logic [2:0] {
      FC_OUT_OV = 3'd0,
      FC_OUT_UV = 3'd1,
      FC_IN_OV  = 3'd2,
      FC_IN_UV  = 3'd3,
      FC_TMO    = 3'd4
   } fclass_e;

   typedef enum logic [AW-1:0] {
      RA_SEL    = 3'd0,
      RA_SECS   = 3'd1,
      RA_TICKS  = 3'd2,
      RA_CTRL   = 3'd3,
      RA_MASTER = 3'd4,
      RA_PGEN   = 3'd5,
      RA_LDATA  = 3'd6,
      RA_LTIME  = 3'd7
   } raddr_e;

   typedef struct packed {
      logic [7:0]  code;
      logic [7:0]  page;
      logic [31:0] secs;
   } entry_t;
endpackage

// File: rtl/flog_tod.sv
module flog_tod #(
   parameter int          TW     = 32,
   parameter logic [31:0] CLK_HZ = 32'd50_000_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_secs,
   input  logic          ld_ticks,
   input  logic [TW-1:0] wdata,
   output logic [TW-1:0] secs,
   output logic [TW-1:0] ticks
);
   logic [TW-1:0] phase;
   logic          wrap;

   generate
      if (TW < 8) begin : g_bad_tw
         $error("flog_tod: TW must be at least 8");
      end
   endgenerate

   assign wrap = (ticks <= TW'(1)) || (phase >= ticks - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secs  <= '0;
         ticks <= TW'(CLK_HZ);
         phase <= '0;
      end else begin
         if (ld_ticks) ticks <= wdata;
         if (ld_secs || ld_ticks) begin
            phase <= '0;
         end else if (wrap) begin
            phase <= '0;
         end else begin
            phase <= phase + TW'(1);
         end
         if (ld_secs) begin
            secs <= wdata;
         end else if (!ld_ticks && wrap) begin
            secs <= secs + TW'(1);
         end
      end
   end
endmodule

// File: rtl/flog_gate.sv
module flog_gate
   import flog_pkg::*;
#(
   parameter int NUM_PAGES = 16
) (
   input  logic [NCLS-1:0]        req,
   input  logic [NCLS*PGW-1:0]    pages,
   input  logic [3:0]             master,
   input  logic [NUM_PAGES*3-1:0] pg_en,
   output logic [NCLS-1:0]        accept
);
   generate
      for (genvar k = 0; k < NCLS; k++) begin : g_cls
         logic [PGW-1:0] pg;
         logic           in_rng;
         logic [2:0]     en3;
         logic           cls_ok;
         assign pg     = pages[k*PGW +: PGW];
         assign in_rng = (32'(pg) < NUM_PAGES);
         always_comb begin
            en3 = 3'b000;
            for (int p = 0; p < NUM_PAGES; p++) begin
               if (32'(pg) == p) en3 = pg_en[p*3 +: 3];
            end
         end
         if (k == int'(FC_OUT_OV)) begin : g_oov
            assign cls_ok = in_rng & en3[0];
         end else if (k == int'(FC_OUT_UV)) begin : g_ouv
            assign cls_ok = in_rng & en3[1];
         end else if (k == int'(FC_IN_OV)) begin : g_iov
            assign cls_ok = master[2];
         end else if (k == int'(FC_IN_UV)) begin : g_iuv
            assign cls_ok = master[3];
         end else begin : g_tmo
            assign cls_ok = in_rng & en3[2];
         end
         assign accept[k] = req[k] & master[0] & cls_ok;
      end
   endgenerate
endmodule

// File: rtl/flog_store.sv
module flog_store
   import flog_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic [NCLS-1:0]      accept,
   input  logic [NCLS*PGW-1:0]  pages,
   input  logic [31:0]          secs,
   input  logic [7:0]           rd_idx,
   output logic [CW-1:0]        count,
   output entry_t               rd_entry
);
   localparam int SW = CW + 3;

   entry_t        mem [DEPTH];
   logic [SW-1:0] slot [NCLS];
   logic [SW-1:0] total;

   generate
      if (DEPTH < 1 || DEPTH > 255) begin : g_bad_depth
         $error("flog_store: DEPTH must be 1..255");
      end
   endgenerate

   always_comb begin
      logic [SW-1:0] run;
      run = SW'(count);
      for (int k = 0; k < NCLS; k++) begin
         slot[k] = run;
         run     = run + SW'(accept[k]);
      end
      total = run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (total >= SW'(DEPTH)) begin
         count <= CW'(DEPTH);
      end else begin
         count <= CW'(total);
      end
   end

   always_ff @(posedge clk) begin
      if (!clear) begin
         for (int k = 0; k < NCLS; k++) begin
            if (accept[k] && (slot[k] < SW'(DEPTH))) begin
               mem[slot[k][CW-1:0]] <= '{code: 8'(1 << k),
                                         page: pages[k*PGW +: PGW],
                                         secs: secs};
            end
         end
      end
   end

   always_comb begin
      rd_entry = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if ((32'(rd_idx) == i) && (32'(rd_idx) < 32'(count))) rd_entry = mem[i];
      end
   end
endmodule

// File: rtl/fault_evlog.sv
module fault_evlog
   import flog_pkg::*;
#(
   parameter int          DEPTH     = 16,
   parameter int          NUM_PAGES = 16,
   parameter logic [31:0] CLK_HZ    = 32'd50_000_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [2:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [4:0]           flt_req,
   input  logic [39:0]          flt_page
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (NUM_PAGES < 1 || NUM_PAGES > 256) begin : g_bad_pages
         $error("fault_evlog: NUM_PAGES must be 1..256");
      end
   endgenerate

   logic [7:0]             pg_sel;
   logic [7:0]             rd_idx;
   logic [3:0]             mst_en;
   logic [NUM_PAGES*3-1:0] pg_en;
   logic [2:0]             pg_en_cur;
   logic [31:0]            tod_sec;
   logic [31:0]            tod_ticks;
   logic [CW-1:0]          log_cnt;
   logic [NCLS-1:0]        accept;
   logic                   clr_log;
   entry_t                 rd_entry;
   logic                   wr_sel, wr_secs, wr_ticks, wr_ctrl, wr_mst, wr_pgen;

   assign wr_sel   = reg_we && (reg_addr == RA_SEL);
   assign wr_secs  = reg_we && (reg_addr == RA_SECS);
   assign wr_ticks = reg_we && (reg_addr == RA_TICKS);
   assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
   assign wr_mst   = reg_we && (reg_addr == RA_MASTER);
   assign wr_pgen  = reg_we && (reg_addr == RA_PGEN);
   assign clr_log  = wr_ctrl && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_sel <= '0;
         rd_idx <= '0;
         mst_en <= '0;
      end else begin
         if (wr_sel)  pg_sel <= reg_wdata[7:0];
         if (wr_ctrl) rd_idx <= reg_wdata[23:16];
         if (wr_mst)  mst_en <= {reg_wdata[3:2], 1'b0, reg_wdata[0]};
      end
   end

   generate
      for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pgen
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pg_en[p*3 +: 3] <= '0;
            end else if (wr_pgen && (32'(pg_sel) == p)) begin
               pg_en[p*3 +: 3] <= reg_wdata[2:0];
            end
         end
      end
   endgenerate

   always_comb begin
      pg_en_cur = '0;
      for (int p = 0; p < NUM_PAGES; p++) begin
         if (32'(pg_sel) == p) pg_en_cur = pg_en[p*3 +: 3];
      end
   end

   flog_tod #(.TW(32), .CLK_HZ(CLK_HZ)) i_tod (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_secs  (wr_secs),
      .ld_ticks (wr_ticks),
      .wdata    (reg_wdata),
      .secs     (tod_sec),
      .ticks    (tod_ticks)
   );

   flog_gate #(.NUM_PAGES(NUM_PAGES)) i_gate (
      .req    (flt_req),
      .pages  (flt_page),
      .master (mst_en),
      .pg_en  (pg_en),
      .accept (accept)
   );

   flog_store #(.DEPTH(DEPTH), .CW(CW)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clr_log),
      .accept   (accept),
      .pages    (flt_page),
      .secs     (tod_sec),
      .rd_idx   (rd_idx),
      .count    (log_cnt),
      .rd_entry (rd_entry)
   );

   always_comb begin
      case (reg_addr)
         RA_SEL:    reg_rdata = {24'b0, pg_sel};
         RA_SECS:   reg_rdata = tod_sec;
         RA_TICKS:  reg_rdata = tod_ticks;
         RA_CTRL:   reg_rdata = {8'(log_cnt), rd_idx, 16'b0};
         RA_MASTER: reg_rdata = {28'b0, mst_en};
         RA_PGEN:   reg_rdata = {29'b0, pg_en_cur};
         RA_LDATA:  reg_rdata = {16'b0, rd_entry.code, rd_entry.page};
         default:   reg_rdata = rd_entry.secs;
      endcase
   end
endmodule

// File: rtl/flog_chk.sv
module flog_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [2:0]    reg_addr,
   input logic [31:0]   reg_wdata,
   input logic [31:0]   reg_rdata,
   input logic [CW-1:0] cnt,
   input logic [31:0]   tod,
   input logic [3:0]    master,
   input logic [7:0]    rd_idx
);
   logic clr;
   assign clr = reg_we && (reg_addr == 3'd3) && reg_wdata[0];

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= DEPTH);                                                   // R9
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));                                                 // R10
   AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt >= $past(cnt)));                                        // R9
   AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!master[0] && !clr) |=> (cnt == $past(cnt)));                        // R6
   AST_SECS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == 3'd1) |=>
         ((tod == $past(tod)) || (tod == $past(tod) + 32'd1)));            // R2
   AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_addr == 3'd6) && (32'(rd_idx) >= 32'(cnt))) |-> (reg_rdata == 32'd0)); // R11
endmodule

bind fault_evlog flog_chk #(.DEPTH(DEPTH)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .cnt       (log_cnt),
   .tod       (tod_sec),
   .master    (mst_en),
   .rd_idx    (rd_idx)
);

// File: tb/test_fault_evlog.sv
module test_fault_evlog;
   localparam int  CLK_PERIOD = 10;
   localparam int  DEPTH      = 4;
   localparam int  NPG        = 4;
   localparam logic [31:0] HZ = 32'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [4:0]  flt_req = '0;
   logic [39:0] flt_page = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fault_evlog #(.DEPTH(DEPTH), .NUM_PAGES(NPG), .CLK_HZ(HZ)) i_fault_evlog (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .flt_req(flt_req), .flt_page(flt_page)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_now(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_now(a, d);
   endtask

   task automatic fire(logic [4:0] m, logic [39:0] pg);
      @(negedge clk);
      flt_req = m; flt_page = pg;
      @(negedge clk);
      flt_req = '0;
   endtask

   task automatic read_entry(int idx, output logic [31:0] dat, output logic [31:0] tim);
      wr(3'd3, 32'(idx) << 16);
      rd_now(3'd6, dat);
      rd_now(3'd7, tim);
   endtask

   function automatic logic [39:0] pages_std();
      return {8'd3, 8'd3, 8'd2, 8'd1, 8'd0};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v, t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(3'd2, v); check("R1 ticks", v, HZ);
      rd_now(3'd3, v); check("R1 ctrl", v, 32'd0);
      rd_now(3'd4, v); check("R1 master", v, 32'd0);
      rd_now(3'd0, v); check("R1 sel", v, 32'd0);
      rd_now(3'd5, v); check("R1 pgen", v, 32'd0);

      // R6 reserved master bits, R7 page enable readback
      wr(3'd4, 32'hFFFF_FFFF);
      rd_now(3'd4, v); check("R6 master readback", v, 32'hD);
      for (int p = 0; p < NPG; p++) begin
         wr(3'd0, 32'(p));
         wr(3'd5, 32'(7 - p));
      end
      for (int p = 0; p < NPG; p++) begin
         wr(3'd0, 32'(p));
         rd_now(3'd5, v); check("R7 pgen readback", v, 32'(7 - p));
      end
      for (int p = 0; p < NPG; p++) begin
         wr(3'd0, 32'(p));
         wr(3'd5, 32'd7);
      end

      // R8 R4 R9 R11: sweep of all simultaneous request masks
      for (int m = 0; m < 32; m++) begin
         int exp_n;
         int k_of [8];
         exp_n = 0;
         wr(3'd3, 32'd1);
         fire(5'(m), pages_std());
         for (int k = 0; k < 5; k++) begin
            if (m[k] && exp_n < DEPTH) begin
               k_of[exp_n] = k;
               exp_n++;
            end
         end
         rd(3'd3, v);
         check("R9 count", {24'b0, v[31:24]}, 32'(exp_n));
         for (int i = 0; i < DEPTH + 2; i++) begin
            logic [31:0] e;
            read_entry(i, v, t);
            if (i < exp_n) begin
               e = (32'd1 << (8 + k_of[i])) | 32'(pages_std() >> (8 * k_of[i]) & 40'hFF);
               check("R8 R4 entry", v, e);
            end else begin
               check("R11 data zero", v, 32'd0);
               check("R11 time zero", t, 32'd0);
            end
         end
      end

      // R9 saturation: full log drops further events
      wr(3'd3, 32'd1);
      fire(5'b11111, pages_std());
      fire(5'b00001, 40'd0);
      rd(3'd3, v); check("R9 saturate", {24'b0, v[31:24]}, 32'(DEPTH));
      read_entry(0, v, t); check("R9 first kept", v, 32'h0000_0100);

      // R12 count read-only
      wr(3'd3, 32'hFF00_0000);
      rd_now(3'd3, v); check("R12 count ro", {24'b0, v[31:24]}, 32'(DEPTH));
      wr(3'd3, 32'h0002_0000);
      rd_now(3'd3, v); check("R12 index field", v, {8'(DEPTH), 8'd2, 16'd0});

      // R10 clear wins over same-cycle events, bit0 reads zero
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd1;
      flt_req = 5'b00011; flt_page = pages_std();
      @(negedge clk);
      reg_we = 1'b0; flt_req = '0;
      rd_now(3'd3, v); check("R10 clear wins", v, 32'd0);

      // R6 master gating sweep (page enables all on)
      for (int mv = 0; mv < 16; mv++) begin
         int exp_n;
         wr(3'd4, 32'(mv));
         wr(3'd3, 32'd1);
         fire(5'b11111, pages_std());
         exp_n = 0;
         if (mv[0]) exp_n = 3 + (mv[2] ? 1 : 0) + (mv[3] ? 1 : 0);
         if (exp_n > DEPTH) exp_n = DEPTH;
         rd(3'd3, v); check("R6 gated count", {24'b0, v[31:24]}, 32'(exp_n));
      end

      // R7 per-page gating sweep on page 1, page 0 disabled, out-of-range page
      wr(3'd4, 32'hD);
      wr(3'd0, 32'd0); wr(3'd5, 32'd0);
      wr(3'd0, 32'd1);
      for (int pe = 0; pe < 8; pe++) begin
         int exp_n;
         wr(3'd5, 32'(pe));
         wr(3'd3, 32'd1);
         fire(5'b10011, {8'd1, 8'd0, 8'd0, 8'd1, 8'd1});
         fire(5'b10011, {8'd0, 8'd0, 8'd0, 8'd0, 8'd0});
         fire(5'b10011, {8'd9, 8'd0, 8'd0, 8'd9, 8'd9});
         exp_n = int'(pe[0]) + int'(pe[1]) + int'(pe[2]);
         rd(3'd3, v); check("R7 page gating", {24'b0, v[31:24]}, 32'(exp_n));
      end

      // R3 R2 seconds counter phase and load
      wr(3'd2, 32'd3);
      rd_now(3'd2, v); check("R3 ticks rw", v, 32'd3);
      for (int n = 0; n < 8; n++) begin
         wr(3'd1, 32'd100);
         repeat (n) @(negedge clk);
         rd_now(3'd1, v); check("R2 secs", v, 32'd100 + 32'(n / 3));
      end
      wr(3'd2, 32'd0);
      wr(3'd1, 32'd50);
      repeat (4) @(negedge clk);
      rd_now(3'd1, v); check("R3 ticks zero", v, 32'd54);
      wr(3'd2, 32'd1);
      wr(3'd1, 32'd7);
      repeat (2) @(negedge clk);
      rd_now(3'd1, v); check("R3 ticks one", v, 32'd9);

      // R5 timestamp of captured entry
      wr(3'd2, 32'd3);
      for (int kx = 0; kx < 7; kx++) begin
         wr(3'd3, 32'd1);
         wr(3'd1, 32'd200);
         repeat (kx) @(negedge clk);
         fire(5'b00100, 40'd0);
         read_entry(0, v, t);
         check("R5 timestamp", t, 32'd200 + 32'((1 + kx) / 3));
         check("R4 input ov code", v, 32'h0000_0400);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule